// File: doc/BRIEF.md
# Descriptor-Driven Configuration Item DMA Engine

This block moves the bytes of one configuration item into system memory on behalf of the host. Software builds a 16-byte descriptor in memory and rings a doorbell with the descriptor's 64-bit address. The engine then fetches the descriptor over a byte-wide master port. It may switch to a new item key, and then copies, skips or zero-fills bytes. It ends by writing a status word back into the descriptor.

The current key and byte offset are shared with a simple host data port. Bytes streamed through that port and bytes moved by the engine advance the same cursor. The item contents live outside the block: the engine presents the key and offset and receives presence, length and the byte at that offset. A read of the register port returns a fixed ASCII signature, and a separate output carries the interface version word.

Top module: `cfg_dma_engine`

## Requirements
- R1: A 4-byte register write at offset 4 starts a transfer, using the upper address half from an earlier 4-byte write at offset 0 and the lower half from this write. An 8-byte write at offset 0 starts a transfer with the full 64-bit address. A write of any other size or at any other offset starts nothing.
- R2: A register read of size 1, 2, 4 or 8 at byte offset `o` returns bytes o..o+size-1 of the signature "CFG-DMA!", with byte 0 in the most significant position. A read that runs past byte 7, or uses another size, returns 0. `verWord` reads 0x00000003.
- R3: The descriptor is fetched as 16 byte reads at ascending addresses starting at the doorbell address. Bytes 0-3 hold the control word, bytes 4-7 the length and bytes 8-15 the target address, each most significant byte first.
- R4: Control bit 3 (0x08) selects the key in control bits 31:16 and resets the offset to 0 before the data phase. Without it, the current key and offset carry over.
- R5: Control bit 1 (0x02, read) takes precedence over skip. It writes `length` bytes to ascending target addresses: item bytes while the offset is inside a present item, advancing the offset, and 0x00 for every byte past the item end or for an absent key.
- R6: Control bit 2 (0x04, skip, without read) advances the offset by the smaller of the length and the bytes left in the item. It makes no memory writes.
- R7: A control word with neither read nor skip set makes no data writes and reports success.
- R8: Completion writes a 32-bit status to descriptor bytes 0-3, most significant byte first. The status is 0 on success. If a data write returns an error, the transfer stops at once, that byte does not advance the offset, and the status is the original control word with bit 0 set.
- R9: If any descriptor fetch read returns an error, no data is moved and the status written back is 0x00000001.
- R10: While a transfer is in progress, doorbell writes and host data-port strobes are ignored. Starting a transfer clears the stored upper address half to 0.
- R11: When idle, `hostSelEn` selects `hostSelKey` with offset 0. `hostRdByte` shows the byte at the cursor, or 0 outside a present item, and a `hostRdEn` pulse advances the offset only inside the item. A select and a doorbell start in the same cycle both take effect.
- R12: A memory request keeps `memReq`, `memWe`, `memAddr` and `memWrData` unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register byte offset |
| regSize | input | 4 | Access size in bytes |
| regWrData | input | 64 | Write data, right-aligned |
| regRdData | output | 64 | Signature read data, right-aligned |
| verWord | output | 32 | Interface version word |
| dmaActive | output | 1 | Transfer in progress |
| hostSelEn | input | 1 | Host key select strobe |
| hostSelKey | input | 16 | Key for host select |
| hostRdEn | input | 1 | Host byte consume strobe |
| hostRdByte | output | 8 | Byte at the shared cursor |
| itemKey | output | 16 | Current key to the item store |
| itemOffset | output | 32 | Current offset to the item store |
| itemPresent | input | 1 | Key has an item |
| itemLen | input | 32 | Item length in bytes |
| itemByte | input | 8 | Item byte at key/offset |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 64 | Byte address |
| memWrData | output | 8 | Write byte |
| memAck | input | 1 | Request completed |
| memErr | input | 1 | Completion with error, valid with ack |
| memRdData | input | 8 | Read byte, valid with ack |

## Verification
Two functions can act in the same cycle: the doorbell start and a host key select. Both are legal only while idle, and both touch the shared cursor. The bench drives both strobes in one cycle, using a descriptor without the select bit, and expects the engine to copy from the newly selected key starting at offset 0. Host strobes and doorbell writes issued mid-transfer are judged by the bytes copied, the number of transfers started and the cursor afterwards.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;
  localparam int ADDR_W = 64;
  localparam int LEN_W  = 32;
  localparam int KEY_W  = 16;
  localparam int CNT_W  = 4;
  localparam int DESC_BYTES = 16;
  localparam int STAT_BYTES = 4;

  // control word bit positions, fixed by the descriptor format
  localparam int BIT_ERR  = 0;
  localparam int BIT_READ = 1;
  localparam int BIT_SKIP = 2;
  localparam int BIT_SEL  = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECIDE, ST_XFER, ST_WB
  } state_e;

  typedef struct packed {
    logic loadDesc;
    logic capDesc;
    logic clrCnt;
    logic incCnt;
    logic applySel;
    logic stepItem;
    logic stepFill;
    logic clrLen;
    logic setXferErr;
    logic setFetchErr;
    logic useTgt;
    logic useWb;
    logic hostSel;
    logic hostAdv;
  } dp_ctl_t;

  typedef struct packed {
    logic lenZero;
    logic inItem;
    logic modeRead;
    logic modeSkip;
    logic selReq;
    logic cntFetchLast;
    logic cntWbLast;
  } dp_stat_t;
endpackage

// File: rtl/cfg_dma_regif.sv
module cfg_dma_regif
  import cfg_dma_pkg::*;
#(
  parameter logic [63:0] SIG_WORD = 64'h4346_472D_444D_4121
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [3:0]        regSize,
  input  logic [63:0]       regWrData,
  input  logic              engineBusy,
  output logic [63:0]       regRdData,
  output logic              startPulse,
  output logic [ADDR_W-1:0] startAddr
);
  localparam int HALF_W = ADDR_W / 2;

  logic [HALF_W-1:0] addrHi;
  logic hiWr, loWr, fullWr, idleWr;
  logic sizeOk, rangeOk;
  logic [3:0] rdGap;
  logic [6:0] rdShift;
  logic [63:0] rdMask;

  assign idleWr = regWrEn && !engineBusy;
  assign hiWr   = idleWr && (regSize == 4'd4) && (regAddr == 3'd0);
  assign loWr   = idleWr && (regSize == 4'd4) && (regAddr == 3'd4);
  assign fullWr = idleWr && (regSize == 4'd8) && (regAddr == 3'd0);

  assign startPulse = loWr || fullWr;
  assign startAddr  = fullWr ? regWrData : {addrHi, regWrData[HALF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrHi <= '0;
    end else if (startPulse) begin
      addrHi <= '0;
    end else if (hiWr) begin
      addrHi <= regWrData[HALF_W-1:0];
    end
  end

  always_comb begin
    sizeOk  = (regSize == 4'd1) || (regSize == 4'd2) ||
              (regSize == 4'd4) || (regSize == 4'd8);
    rangeOk = ({1'b0, regAddr} + regSize) <= 4'd8;
    rdGap   = 4'd8 - {1'b0, regAddr} - regSize;
    rdShift = {rdGap[2:0], 3'b000} | {rdGap[3], 6'b0};
    rdMask  = (regSize == 4'd8) ? '1 : ((64'h1 << {regSize[2:0], 3'b000}) - 64'h1);
    regRdData = (sizeOk && rangeOk) ? ((SIG_WORD >> rdShift) & rdMask) : '0;
  end
endmodule

// File: rtl/cfg_dma_ctrl.sv
module cfg_dma_ctrl
  import cfg_dma_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startPulse,
  input  dp_stat_t stat,
  input  logic     memAck,
  input  logic     memErr,
  input  logic     hostSelEn,
  input  logic     hostRdEn,
  output dp_ctl_t  ctl,
  output logic     memReq,
  output logic     memWe,
  output logic     busy
);
  state_e state, stateNx;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNx;
  end

  assign busy = (state != ST_IDLE);

  always_comb begin
    ctl     = '0;
    memReq  = 1'b0;
    memWe   = 1'b0;
    stateNx = state;
    unique case (state)
      ST_IDLE: begin
        ctl.hostSel = hostSelEn;
        ctl.hostAdv = hostRdEn && !hostSelEn;
        if (startPulse) begin
          ctl.loadDesc = 1'b1;
          stateNx      = ST_FETCH;
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          if (memErr) begin
            ctl.setFetchErr = 1'b1;
            ctl.clrCnt      = 1'b1;
            stateNx         = ST_WB;
          end else begin
            ctl.capDesc = 1'b1;
            ctl.incCnt  = 1'b1;
            if (stat.cntFetchLast) stateNx = ST_DECIDE;
          end
        end
      end
      ST_DECIDE: begin
        ctl.applySel = stat.selReq;
        ctl.clrCnt   = 1'b1;
        if (!stat.modeRead && !stat.modeSkip) begin
          ctl.clrLen = 1'b1;
          stateNx    = ST_WB;
        end else begin
          stateNx = ST_XFER;
        end
      end
      ST_XFER: begin
        ctl.useTgt = 1'b1;
        if (stat.lenZero) begin
          ctl.clrCnt = 1'b1;
          stateNx    = ST_WB;
        end else if (stat.modeRead) begin
          memReq = 1'b1;
          memWe  = 1'b1;
          if (memAck) begin
            if (memErr) begin
              ctl.setXferErr = 1'b1;
              ctl.clrCnt     = 1'b1;
              stateNx        = ST_WB;
            end else if (stat.inItem) begin
              ctl.stepItem = 1'b1;
            end else begin
              ctl.stepFill = 1'b1;
            end
          end
        end else if (stat.inItem) begin
          ctl.stepItem = 1'b1;
        end else begin
          ctl.clrLen = 1'b1;
        end
      end
      ST_WB: begin
        ctl.useWb = 1'b1;
        memReq    = 1'b1;
        memWe     = 1'b1;
        if (memAck) begin
          ctl.incCnt = 1'b1;
          if (stat.cntWbLast) stateNx = ST_IDLE;
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/cfg_dma_datapath.sv
module cfg_dma_datapath
  import cfg_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [7:0]        memRdData,
  input  logic              itemPresent,
  input  logic [LEN_W-1:0]  itemLen,
  input  logic [7:0]        itemByte,
  input  logic [KEY_W-1:0]  hostSelKey,
  output dp_stat_t          stat,
  output logic [KEY_W-1:0]  itemKey,
  output logic [LEN_W-1:0]  itemOffset,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData,
  output logic [7:0]        hostRdByte
);
  logic [ADDR_W-1:0] descAddr, tgtAddr;
  logic [31:0]       ctrlWord, wbWord;
  logic [LEN_W-1:0]  lenReg, curOffset;
  logic [KEY_W-1:0]  curKey;
  logic [CNT_W-1:0]  cnt;
  logic              xferErr, fetchErr;
  logic              inItem;
  logic [7:0]        cursorByte;

  assign inItem     = itemPresent && (curOffset < itemLen);
  assign cursorByte = inItem ? itemByte : 8'h00;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descAddr  <= '0;
      tgtAddr   <= '0;
      ctrlWord  <= '0;
      lenReg    <= '0;
      curKey    <= '0;
      curOffset <= '0;
      cnt       <= '0;
      xferErr   <= 1'b0;
      fetchErr  <= 1'b0;
    end else begin
      if (ctl.loadDesc) begin
        descAddr <= startAddr;
        cnt      <= '0;
        xferErr  <= 1'b0;
        fetchErr <= 1'b0;
      end
      if (ctl.clrCnt) cnt <= '0;
      else if (ctl.incCnt) cnt <= cnt + 1'b1;
      if (ctl.capDesc) begin
        {ctrlWord, lenReg, tgtAddr} <= {ctrlWord[23:0], lenReg, tgtAddr, memRdData};
      end
      if (ctl.setXferErr)  xferErr  <= 1'b1;
      if (ctl.setFetchErr) fetchErr <= 1'b1;
      if (ctl.clrLen) lenReg <= '0;
      if (ctl.stepItem || ctl.stepFill) begin
        lenReg  <= lenReg - 1'b1;
        tgtAddr <= tgtAddr + 1'b1;
      end
      if (ctl.applySel) begin
        curKey    <= ctrlWord[31:16];
        curOffset <= '0;
      end else if (ctl.hostSel) begin
        curKey    <= hostSelKey;
        curOffset <= '0;
      end else if (ctl.stepItem || (ctl.hostAdv && inItem)) begin
        curOffset <= curOffset + 1'b1;
      end
    end
  end

  always_comb begin
    if (fetchErr)     wbWord = 32'h0000_0001;
    else if (xferErr) wbWord = ctrlWord | 32'h0000_0001;
    else              wbWord = 32'h0000_0000;
  end

  assign memAddr    = ctl.useTgt ? tgtAddr : (descAddr + ADDR_W'(cnt));
  assign memWrData  = ctl.useWb ? wbWord[8*(3-cnt[1:0]) +: 8] : cursorByte;
  assign hostRdByte = cursorByte;
  assign itemKey    = curKey;
  assign itemOffset = curOffset;

  assign stat.lenZero      = (lenReg == '0);
  assign stat.inItem       = inItem;
  assign stat.modeRead     = ctrlWord[BIT_READ];
  assign stat.modeSkip     = ctrlWord[BIT_SKIP];
  assign stat.selReq       = ctrlWord[BIT_SEL];
  assign stat.cntFetchLast = (cnt == CNT_W'(DESC_BYTES - 1));
  assign stat.cntWbLast    = (cnt == CNT_W'(STAT_BYTES - 1));
endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
  import cfg_dma_pkg::*;
#(
  parameter logic [63:0] SIG_WORD = 64'h4346_472D_444D_4121,
  parameter bit          HAS_DMA  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [3:0]        regSize,
  input  logic [63:0]       regWrData,
  output logic [63:0]       regRdData,
  output logic [31:0]       verWord,
  output logic              dmaActive,
  input  logic              hostSelEn,
  input  logic [KEY_W-1:0]  hostSelKey,
  input  logic              hostRdEn,
  output logic [7:0]        hostRdByte,
  output logic [KEY_W-1:0]  itemKey,
  output logic [LEN_W-1:0]  itemOffset,
  input  logic              itemPresent,
  input  logic [LEN_W-1:0]  itemLen,
  input  logic [7:0]        itemByte,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData,
  input  logic              memAck,
  input  logic              memErr,
  input  logic [7:0]        memRdData
);
  logic              startPulse;
  logic [ADDR_W-1:0] startAddr;
  dp_ctl_t           ctl;
  dp_stat_t          stat;

  assign verWord = {30'b0, HAS_DMA, 1'b1};

  cfg_dma_regif #(.SIG_WORD(SIG_WORD)) regif_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regSize(regSize), .regWrData(regWrData), .engineBusy(dmaActive),
    .regRdData(regRdData), .startPulse(startPulse), .startAddr(startAddr)
  );

  cfg_dma_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .stat(stat),
    .memAck(memAck), .memErr(memErr), .hostSelEn(hostSelEn),
    .hostRdEn(hostRdEn), .ctl(ctl), .memReq(memReq), .memWe(memWe),
    .busy(dmaActive)
  );

  cfg_dma_datapath dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startAddr(startAddr),
    .memRdData(memRdData), .itemPresent(itemPresent), .itemLen(itemLen),
    .itemByte(itemByte), .hostSelKey(hostSelKey), .stat(stat),
    .itemKey(itemKey), .itemOffset(itemOffset), .memAddr(memAddr),
    .memWrData(memWrData), .hostRdByte(hostRdByte)
  );
endmodule

// File: rtl/cfg_dma_checker.sv
module cfg_dma_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [2:0]  regAddr,
  input logic [3:0]  regSize,
  input logic        dmaActive,
  input logic        startPulse,
  input logic        memReq,
  input logic        memWe,
  input logic [63:0] memAddr,
  input logic [7:0]  memWrData,
  input logic        memAck,
  input logic        memErr
);
  // R12: an unacknowledged request is held unchanged
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe) && $stable(memAddr) && $stable(memWrData)));

  // R10: no bus traffic outside a transfer
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !dmaActive |-> !memReq);

  // R1: a full-width doorbell write while idle starts a transfer
  a_r1_full_start: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSize == 4'd8 && regAddr == 3'd0 && !dmaActive) |=> dmaActive);

  // R1: the register decode start strobe leads to an active engine
  a_r1_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> dmaActive);

  // R8: every transfer ends on an acknowledged write (status write-back)
  a_r8_end_on_wb: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dmaActive) |-> $past(memReq && memWe && memAck));

  // R9: a failed descriptor read is followed by the status write
  a_r9_fetch_err_wb: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && memAck && memErr) |=> (memReq && memWe));
endmodule

bind cfg_dma_engine cfg_dma_checker chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regSize(regSize), .dmaActive(dmaActive), .startPulse(startPulse),
  .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
  .memWrData(memWrData), .memAck(memAck), .memErr(memErr)
);

// File: tb/cfg_dma_engine_tb_top.sv
`timescale 1ns/1ps
module cfg_dma_engine_tb_top;
  localparam logic [63:0] SIG = 64'h4346_472D_444D_4121;
  localparam int DESC = 'h100;
  localparam int TGT  = 'h200;
  localparam logic [31:0] TGT_HI = 32'hA000_0001;

  logic clk = 0, rstN = 0;
  always #2.5 clk = ~clk;

  logic regWrEn = 0; logic [2:0] regAddr = 0; logic [3:0] regSize = 0;
  logic [63:0] regWrData = 0, regRdData; logic [31:0] verWord;
  logic dmaActive, hostSelEn = 0, hostRdEn = 0; logic [15:0] hostSelKey = 0;
  logic [7:0] hostRdByte; logic [15:0] itemKey; logic [31:0] itemOffset;
  logic itemPresent; logic [31:0] itemLen; logic [7:0] itemByte;
  logic memReq, memWe; logic [63:0] memAddr; logic [7:0] memWrData;
  logic memAck = 0, memErr = 0; logic [7:0] memRdData = 0;

  cfg_dma_engine dut_i (.*);

  int nChk = 0, nBad = 0, cyc = 0;
  logic [7:0] mem [1024];
  logic errOn = 0; logic [9:0] errIdx = 0;
  logic [63:0] lastRdAddr = 0;
  int stage = 0, holdBad = 0, starts = 0;
  logic [63:0] hAddr; logic hWe; logic [7:0] hData;
  logic prevAct = 0;
  int mKey = 0, mOff = 0;

  function automatic bit presM(int k); return k < 4; endfunction
  function automatic int lenM(int k); return k * 3 + 1; endfunction
  function automatic logic [7:0] byteM(int k, int o); return 8'((k * 37 + o * 5 + 3) & 255); endfunction
  function automatic bit inM(int k, int o); return presM(k) && o < lenM(k); endfunction

  assign itemPresent = presM(int'(itemKey));
  assign itemLen     = 32'(lenM(int'(itemKey)));
  assign itemByte    = byteM(int'(itemKey), int'(itemOffset));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: latch request, confirm it is held, then acknowledge
  always @(negedge clk) begin
    cyc++;
    if (dmaActive && !prevAct) starts++;
    prevAct = dmaActive;
    if (!rstN) begin
      stage = 0; memAck = 0; memErr = 0;
    end else if (stage == 0) begin
      if (memReq) begin hAddr = memAddr; hWe = memWe; hData = memWrData; stage = 1; end
    end else if (stage == 1) begin
      if (!(memReq && memAddr == hAddr && memWe == hWe && memWrData == hData)) holdBad++;
      memAck = 1;
      memErr = errOn && (hAddr[9:0] == errIdx);
      if (!hWe) begin memRdData = mem[hAddr[9:0]]; lastRdAddr = hAddr; end
      else if (!memErr) mem[hAddr[9:0]] = hData;
      stage = 2;
    end else begin
      memAck = 0; memErr = 0; stage = 0;
    end
    if (cyc > 150000) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  task automatic regWrite(int off, int sz, logic [63:0] d);
    regWrEn = 1; regAddr = 3'(off); regSize = 4'(sz); regWrData = d;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic waitIdle();
    while (dmaActive) @(negedge clk);
  endtask

  task automatic putDesc(logic [31:0] c, logic [31:0] l);
    logic [127:0] d;
    d = {c, l, TGT_HI, 32'(TGT)};
    for (int i = 0; i < 16; i++) mem[DESC + i] = d[127 - 8*i -: 8];
    for (int i = 0; i < 16; i++) mem[TGT + i] = 8'hEE;
  endtask

  // kind: 0 full 8-byte, 1 hi+lo, 2 lo only; hostKey>=0 selects in start cycle
  task automatic runCase(string tag, logic [31:0] c, int len, int kind, logic [31:0] hi,
                         int hostKey, int dataErr, int fetchErr);
    logic [7:0] expT [16];
    logic [31:0] expS, gotS; bit err;
    putDesc(c, 32'(len));
    for (int i = 0; i < 16; i++) expT[i] = 8'hEE;
    errOn = (dataErr >= 0) || (fetchErr >= 0);
    errIdx = (dataErr >= 0) ? 10'(TGT + dataErr) : 10'(DESC + fetchErr);
    err = 0;
    if (hostKey >= 0) begin mKey = hostKey; mOff = 0; end
    if (fetchErr >= 0) expS = 32'h1;
    else begin
      if (c[3]) begin mKey = int'(c[31:16]); mOff = 0; end
      if (c[1]) begin
        for (int i = 0; i < len; i++) begin
          if (i == dataErr) begin err = 1; break; end
          if (inM(mKey, mOff)) begin expT[i] = byteM(mKey, mOff); mOff++; end
          else expT[i] = 8'h00;
        end
      end else if (c[2]) begin
        int rem;
        rem = inM(mKey, mOff) ? lenM(mKey) - mOff : 0;
        mOff += (len < rem) ? len : rem;
      end
      expS = err ? (c | 32'h1) : 32'h0;
    end
    if (kind == 1) regWrite(0, 4, {32'h0, hi});
    if (hostKey >= 0) begin hostSelEn = 1; hostSelKey = 16'(hostKey); end
    if (kind == 0) regWrite(0, 8, {hi, 32'(DESC)});
    else regWrite(4, 4, {32'h0, 32'(DESC)});
    hostSelEn = 0;
    waitIdle();
    errOn = 0;
    gotS = {mem[DESC], mem[DESC+1], mem[DESC+2], mem[DESC+3]};
    check({tag, " status R8"}, 64'(gotS), 64'(expS));
    for (int i = 0; i < 16; i++) check({tag, " target byte R5"}, 64'(mem[TGT+i]), 64'(expT[i]));
    check({tag, " cursor R6"}, 64'(hostRdByte), 64'(inM(mKey, mOff) ? byteM(mKey, mOff) : 8'h00));
  endtask

  initial begin
    int lens [5] = '{0, 1, 3, 5, 12};
    logic [31:0] modes [3] = '{32'h02, 32'h04, 32'h00};
    int s0;
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("reset idle R10", 64'(dmaActive), 0);
    check("reset no request R12", 64'(memReq), 0);
    check("reset cursor R11", 64'(hostRdByte), 64'(byteM(0, 0)));
    check("version R2", 64'(verWord), 64'h3);

    // R2 signature sweep
    for (int sz = 1; sz <= 8; sz++) for (int o = 0; o < 8; o++) begin
      logic [63:0] e;
      regAddr = 3'(o); regSize = 4'(sz); #0.1;
      if ((sz == 1 || sz == 2 || sz == 4 || sz == 8) && o + sz <= 8)
        e = (SIG >> ((8 - o - sz) * 8)) & ((sz == 8) ? '1 : ((64'h1 << (sz * 8)) - 1));
      else e = 0;
      @(negedge clk);
      check("signature R2", regRdData, e);
    end

    // R11 host data port
    hostSelEn = 1; hostSelKey = 2; @(negedge clk); hostSelEn = 0; mKey = 2; mOff = 0;
    for (int i = 0; i < 9; i++) begin
      check("host stream R11", 64'(hostRdByte), 64'(inM(2, i) ? byteM(2, i) : 8'h00));
      hostRdEn = 1; @(negedge clk); hostRdEn = 0;
      if (inM(mKey, mOff)) mOff++;
    end
    hostSelEn = 1; hostSelKey = 7; @(negedge clk); hostSelEn = 0; mKey = 7; mOff = 0;
    check("absent key R11", 64'(hostRdByte), 0);

    // R1 rejected writes start nothing
    s0 = starts;
    regWrite(0, 2, 64'(DESC)); regWrite(2, 4, 64'(DESC));
    regWrite(4, 8, 64'(DESC)); regWrite(0, 4, 64'h0);
    regWrite(4, 2, 64'(DESC)); regWrite(0, 1, 64'(DESC));
    repeat (4) @(negedge clk);
    check("rejected writes R1", 64'(starts - s0), 0);

    // R4 R5 R6 R7 sweep with select
    for (int k = 0; k < 5; k++) for (int li = 0; li < 5; li++) for (int m = 0; m < 3; m++)
      runCase("sweep R4", {16'(k), 16'h0} | modes[m] | 32'h08, lens[li], 0, 32'h0, -1, -1, -1);
    // carry-over without select, read wins over skip
    runCase("skip R6", 32'h0003_000C, 2, 0, 32'h0, -1, -1, -1);
    runCase("carry R4", 32'h0000_0002, 12, 0, 32'h0, -1, -1, -1);
    runCase("precedence R5", 32'h0002_000E, 5, 0, 32'h0, -1, -1, -1);
    runCase("neither R7", 32'h0001_0008, 6, 0, 32'h0, -1, -1, -1);

    // R8 data write error, R9 fetch error
    runCase("werr R8", 32'h0003_000A, 5, 0, 32'h0, -1, 2, -1);
    runCase("ferr R9", 32'h0002_000A, 5, 0, 32'h0, -1, -1, 5);

    // R1 split doorbell, R10 cleared upper half, R3 fetch address
    runCase("split R1", 32'h0001_000A, 3, 1, 32'h0000_00C3, -1, -1, -1);
    check("split upper R3", lastRdAddr, {32'hC3, 32'(DESC + 15)});
    runCase("lo only R10", 32'h0001_000A, 3, 2, 32'h0, -1, -1, -1);
    check("cleared upper R10", lastRdAddr, {32'h0, 32'(DESC + 15)});
    runCase("full R1", 32'h0002_000A, 2, 0, 32'h0000_0055, -1, -1, -1);
    check("full address R3", lastRdAddr, {32'h55, 32'(DESC + 15)});

    // same-cycle start and host select
    runCase("start+select R11", 32'h0000_0002, 5, 0, 32'h0, 1, -1, -1);

    // R10 busy: doorbell and host strobes ignored mid-transfer
    s0 = starts;
    putDesc(32'h0003_000A, 32'd12);
    regWrite(0, 8, 64'(DESC));
    repeat (5) @(negedge clk);
    regWrite(0, 8, 64'h300);
    hostSelEn = 1; hostSelKey = 1; @(negedge clk); hostSelEn = 0;
    hostRdEn = 1; @(negedge clk); hostRdEn = 0;
    waitIdle();
    repeat (6) @(negedge clk);
    mKey = 3; mOff = 10;
    check("busy starts R10", 64'(starts - s0), 1);
    check("busy fetch addr R10", lastRdAddr, 64'(DESC + 15));
    check("busy cursor R10", 64'(hostRdByte), 0);
    check("busy copy R10", 64'(mem[TGT + 9]), 64'(byteM(3, 9)));
    check("busy fill R10", 64'(mem[TGT + 11]), 0);

    check("request hold R12", 64'(holdBad), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule